// File: doc/BRIEF.md
# Pulse-Limit Program and Erase Engine

This block is the device-side engine that writes or erases one byte location of a non-volatile cell array. It works by repeated pulses. When a program or erase request is accepted, the engine sends a pulse to the array and then waits for the array to return the byte now stored at that location. It compares that byte with the target value. For a program, the target is the requested data. For an erase, the target is all ones. If the byte does not match yet, the engine sends another pulse. Each operation has a parameterised budget of pulses. If the budget runs out before the byte matches, the engine raises the exceeded-timing fault flag (status bit 5).

A program pulse can only move bits from 1 to 0. A request to write a 1 over a stored 0 therefore can never succeed. The engine does not reject such a request up front. It keeps pulsing until the budget trips, and then it latches the fault. While the fault is latched, only the reset command is accepted. The engine also provides a status toggle bit (bit 6) that inverts on each status read while an operation is in flight or a fault is latched. The cell array is outside the block. The bench models it behaviourally.

Top module: `pulse_limit_engine`

## Requirements
- R1: After synchronous reset, `busy`, `limit_fault`, `status_tog` and `pulse_v` are all 0.
- R2: In idle, a `prog_req` is accepted on the next clock. `busy` becomes 1, and the pulses that follow carry `req_addr` on `pulse_addr`, `req_data` on `pulse_data` and `pulse_erase`=0. If `prog_req` and `erase_req` arrive together, the program request wins.
- R3: When a returned `verify_data` equals the target, `busy` drops to 0 on the next clock and `limit_fault` stays 0.
- R4: A mismatching result whose pulse was inside the budget causes another one-cycle `pulse_v` strobe to the same location.
- R5: If the result of pulse number PULSE_LIMIT still mismatches, `limit_fault` becomes 1. Exactly PULSE_LIMIT pulses are issued for that operation, never more.
- R6: A program that would raise a stored 0 back to 1 never verifies, so it ends with `limit_fault`=1 after PULSE_LIMIT pulses.
- R7: Once `limit_fault` is 1, it stays 1 and `busy` stays 1 until `reset_cmd`. No pulses are issued, and `prog_req` and `erase_req` have no effect. One clock after `reset_cmd`, both `limit_fault` and `busy` are 0.
- R8: `status_tog` inverts on each clock that has `status_rd` while `busy` is 1 (this includes the latched-fault state). While `busy` is 0 it holds its value.
- R9: An `erase_req` in idle issues pulses with `pulse_erase`=1 and uses the all-ones byte (8'hFF for 8-bit data) as the target.
- R10: While an operation is running, `prog_req`, `erase_req` and `reset_cmd` are ignored. The operation keeps its original address and target.
- R11: The pulse budget restarts at every accepted request. An operation that verifies exactly on pulse PULSE_LIMIT completes without fault, even right after a faulted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req | input | 1 | Program request strobe |
| erase_req | input | 1 | Erase request strobe |
| reset_cmd | input | 1 | Reset command; clears a latched fault |
| req_addr | input | ADDR_W | Byte location of the request |
| req_data | input | DATA_W | Byte to program |
| status_rd | input | 1 | Status read strobe |
| verify_valid | input | 1 | Array returns a read-back after a pulse |
| verify_data | input | DATA_W | Byte stored after the pulse |
| pulse_v | output | 1 | One-cycle pulse command to the array |
| pulse_erase | output | 1 | 1 = erase pulse, 0 = program pulse |
| pulse_addr | output | ADDR_W | Location being pulsed |
| pulse_data | output | DATA_W | Target byte of the operation |
| busy | output | 1 | Operation in flight or fault latched |
| limit_fault | output | 1 | Status bit 5: pulse budget exceeded |
| status_tog | output | 1 | Status bit 6: toggles on reads while busy |

## Verification
The bench drives a cell array in which each location needs a chosen number of pulses before it takes a value. This lets it place success on pulse 1, in mid-budget, exactly on pulse PULSE_LIMIT, and one pulse too late. A design with an off-by-one budget would either fault on the last legal pulse or issue one pulse too many. A design that forgets to clear the counter between requests would fault early on the operation that follows a failure. Programming 1 over 0 checks that the fault really latches: requests made during the fault must produce no pulse and must not clear the flag, and only the reset command may release it. Requests and a reset command issued during a running operation must leave its address, target and pulse count unchanged. Status reads made in idle must leave bit 6 unchanged.

// File: rtl/ple_pkg.sv
package ple_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_FIRE  = 2'd1,
    PS_WAIT  = 2'd2,
    PS_FAULT = 2'd3
  } ple_state_t;
endpackage

// File: rtl/ple_pulse_counter.sv
module ple_pulse_counter #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
  end

  assign at_limit = (cnt == CW'(LIMIT));
endmodule

// File: rtl/ple_verify_cmp.sv
module ple_verify_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] readback,
  input  logic [DATA_W-1:0] target,
  output logic              match
);
  logic [DATA_W-1:0] diff;
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign diff[b] = readback[b] ^ target[b];
  end
  assign match = ~|diff;
endmodule

// File: rtl/ple_status_toggle.sv
module ple_status_toggle (
  input  logic clk,
  input  logic rst,
  input  logic rd,
  input  logic active,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (rst) tog <= 1'b0;
    else if (rd && active) tog <= ~tog;
  end
endmodule

// File: rtl/pulse_limit_engine.sv
module pulse_limit_engine #(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 8,
  parameter int PULSE_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_req,
  input  logic              erase_req,
  input  logic              reset_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              status_rd,
  input  logic              verify_valid,
  input  logic [DATA_W-1:0] verify_data,
  output logic              pulse_v,
  output logic              pulse_erase,
  output logic [ADDR_W-1:0] pulse_addr,
  output logic [DATA_W-1:0] pulse_data,
  output logic              busy,
  output logic              limit_fault,
  output logic              status_tog
);
  import ple_pkg::*;

  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  ple_state_t state;
  logic       cnt_clr, cnt_inc, at_limit, match, accept;

  assign accept  = (state == PS_IDLE) && (prog_req || erase_req);
  assign cnt_clr = accept;
  assign cnt_inc = (state == PS_FIRE);

  ple_pulse_counter #(.LIMIT(PULSE_LIMIT)) cnt_i (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .at_limit(at_limit)
  );

  ple_verify_cmp #(.DATA_W(DATA_W)) cmp_i (
    .readback(verify_data), .target(pulse_data), .match(match)
  );

  ple_status_toggle tog_i (
    .clk(clk), .rst(rst), .rd(status_rd), .active(busy), .tog(status_tog)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PS_IDLE;
      busy        <= 1'b0;
      limit_fault <= 1'b0;
      pulse_v     <= 1'b0;
      pulse_erase <= 1'b0;
      pulse_addr  <= '0;
      pulse_data  <= '0;
    end else begin
      pulse_v <= 1'b0;
      case (state)
        PS_IDLE: begin
          if (prog_req) begin
            pulse_addr  <= req_addr;
            pulse_data  <= req_data;
            pulse_erase <= 1'b0;
            busy        <= 1'b1;
            state       <= PS_FIRE;
          end else if (erase_req) begin
            pulse_addr  <= req_addr;
            pulse_data  <= ERASED;
            pulse_erase <= 1'b1;
            busy        <= 1'b1;
            state       <= PS_FIRE;
          end
        end
        PS_FIRE: begin
          pulse_v <= 1'b1;
          state   <= PS_WAIT;
        end
        PS_WAIT: begin
          if (verify_valid) begin
            if (match) begin
              busy  <= 1'b0;
              state <= PS_IDLE;
            end else if (at_limit) begin
              limit_fault <= 1'b1;
              state       <= PS_FAULT;
            end else begin
              state <= PS_FIRE;
            end
          end
        end
        PS_FAULT: begin
          if (reset_cmd) begin
            limit_fault <= 1'b0;
            busy        <= 1'b0;
            state       <= PS_IDLE;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_limit_engine_chk.sv
module pulse_limit_engine_chk #(
  parameter int PULSE_LIMIT = 6
) (
  input logic clk,
  input logic rst,
  input logic reset_cmd,
  input logic pulse_v,
  input logic busy,
  input logic limit_fault,
  input logic status_tog
);
  int seen;

  always_ff @(posedge clk) begin
    if (rst || !busy) seen <= 0;
    else if (pulse_v) seen <= seen + 1;
  end

  // R2
  pulse_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_v |-> busy);

  // R5
  pulse_budget_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> seen <= PULSE_LIMIT);

  // R5
  fault_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(limit_fault) |-> seen == PULSE_LIMIT);

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (limit_fault && !reset_cmd) |=> (limit_fault && busy));

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    limit_fault |-> !pulse_v);

  // R8
  tog_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(status_tog));

  // R3
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !limit_fault);
endmodule

bind pulse_limit_engine pulse_limit_engine_chk #(.PULSE_LIMIT(PULSE_LIMIT)) chk_i (
  .clk(clk), .rst(rst), .reset_cmd(reset_cmd), .pulse_v(pulse_v),
  .busy(busy), .limit_fault(limit_fault), .status_tog(status_tog)
);

// File: tb/pulse_limit_engine_tb_top.sv
module pulse_limit_engine_tb_top;
  localparam int AW = 21, DW = 8, LIM = 5;

  logic clk = 0, rst = 1;
  logic prog_req = 0, erase_req = 0, reset_cmd = 0, status_rd = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic verify_valid = 0;
  logic [DW-1:0] verify_data = '0;
  logic pulse_v, pulse_erase, busy, limit_fault, status_tog;
  logic [AW-1:0] pulse_addr;
  logic [DW-1:0] pulse_data;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pulse_limit_engine #(.ADDR_W(AW), .DATA_W(DW), .PULSE_LIMIT(LIM)) dut_i (
    .clk(clk), .rst(rst), .prog_req(prog_req), .erase_req(erase_req),
    .reset_cmd(reset_cmd), .req_addr(req_addr), .req_data(req_data),
    .status_rd(status_rd), .verify_valid(verify_valid), .verify_data(verify_data),
    .pulse_v(pulse_v), .pulse_erase(pulse_erase), .pulse_addr(pulse_addr),
    .pulse_data(pulse_data), .busy(busy), .limit_fault(limit_fault),
    .status_tog(status_tog)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural cell array: a location takes its value after `need` pulses
  logic [DW-1:0] mem [16];
  int need = 1, op_pulses = 0;
  logic last_erase = 0;
  initial for (int i = 0; i < 16; i++) mem[i] = 8'hFF;

  always @(negedge clk) begin
    if (pulse_v) begin
      op_pulses++;
      last_erase = pulse_erase;
      if (op_pulses >= need) begin
        if (pulse_erase) mem[pulse_addr[3:0]] = 8'hFF;
        else mem[pulse_addr[3:0]] = mem[pulse_addr[3:0]] & pulse_data;
      end
      verify_valid <= 1'b1;
      verify_data  <= mem[pulse_addr[3:0]];
    end else begin
      verify_valid <= 1'b0;
    end
  end

  // cycle reference model
  int m_st = 0, m_cnt = 0;
  logic m_busy = 0, m_fail = 0, m_tog = 0, m_pv = 0, m_pe = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_tgt = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_busy = 0; m_fail = 0; m_tog = 0; m_pv = 0;
    end else begin
      if (status_rd && m_busy) m_tog = ~m_tog;
      m_pv = 0;
      if (m_st == 0) begin
        if (prog_req) begin
          m_addr = req_addr; m_tgt = req_data; m_pe = 0; m_busy = 1; m_cnt = 0; m_st = 1;
        end else if (erase_req) begin
          m_addr = req_addr; m_tgt = 8'hFF; m_pe = 1; m_busy = 1; m_cnt = 0; m_st = 1;
        end
      end else if (m_st == 1) begin
        m_pv = 1; m_cnt++; m_st = 2;
      end else if (m_st == 2) begin
        if (verify_valid) begin
          if (verify_data == m_tgt) begin m_busy = 0; m_st = 0; end
          else if (m_cnt >= LIM) begin m_fail = 1; m_st = 3; end
          else m_st = 1;
        end
      end else if (reset_cmd) begin
        m_fail = 0; m_busy = 0; m_st = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(busy === m_busy, "R3 busy", 32'(busy), 32'(m_busy));
      chk(limit_fault === m_fail, "R5 fault", 32'(limit_fault), 32'(m_fail));
      chk(status_tog === m_tog, "R8 toggle", 32'(status_tog), 32'(m_tog));
      chk(pulse_v === m_pv, "R4 pulse", 32'(pulse_v), 32'(m_pv));
      if (m_pv) begin
        chk(pulse_erase === m_pe, "R9 erase flag", 32'(pulse_erase), 32'(m_pe));
        chk(pulse_addr === m_addr, "R2 addr", 32'(pulse_addr), 32'(m_addr));
        chk(pulse_data === m_tgt, "R2 data", 32'(pulse_data), 32'(m_tgt));
      end
    end
  end

  task automatic start_prog(input int a, input logic [DW-1:0] d, input int n);
    @(negedge clk);
    need = n; op_pulses = 0;
    prog_req = 1; req_addr = AW'(a); req_data = d;
    @(negedge clk);
    prog_req = 0;
  endtask

  task automatic start_erase(input int a, input int n);
    @(negedge clk);
    need = n; op_pulses = 0;
    erase_req = 1; req_addr = AW'(a);
    @(negedge clk);
    erase_req = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      if (!busy || limit_fault) break;
      @(negedge clk);
    end
  endtask

  task automatic send_reset();
    @(negedge clk); reset_cmd = 1;
    @(negedge clk); reset_cmd = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic t0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", 32'(busy), 0);
    chk(!limit_fault, "R1 fault", 32'(limit_fault), 0);
    chk(!status_tog, "R1 toggle", 32'(status_tog), 0);
    chk(!pulse_v, "R1 pulse", 32'(pulse_v), 0);

    // R3 single pulse success
    start_prog(3, 8'hA5, 1);
    wait_done(); @(negedge clk);
    chk(!busy && !limit_fault, "R3 done", {busy, limit_fault}, 0);
    chk(op_pulses == 1, "R3 pulses", op_pulses, 1);
    chk(mem[3] == 8'hA5, "R3 mem", mem[3], 8'hA5);

    // R2 program wins over erase; R4 multi-pulse
    @(negedge clk);
    need = 3; op_pulses = 0;
    prog_req = 1; erase_req = 1; req_addr = 4; req_data = 8'h3C;
    @(negedge clk); prog_req = 0; erase_req = 0;
    wait_done(); @(negedge clk);
    chk(last_erase == 0, "R2 priority", 32'(last_erase), 0);
    chk(mem[4] == 8'h3C, "R2 mem", mem[4], 8'h3C);
    chk(op_pulses == 3, "R4 pulses", op_pulses, 3);

    // R8 toggling while busy, frozen in idle
    start_prog(5, 8'h0F, 4);
    t0 = status_tog;
    status_rd = 1; @(negedge clk); status_rd = 0;
    chk(status_tog == ~t0, "R8 busy read", 32'(status_tog), 32'(~t0));
    wait_done(); @(negedge clk);
    t0 = status_tog;
    status_rd = 1; @(negedge clk); @(negedge clk); status_rd = 0;
    chk(status_tog == t0, "R8 idle read", 32'(status_tog), 32'(t0));

    // R6 / R5: program 1 over 0 at location 3 (A5)
    start_prog(3, 8'hFF, 1);
    wait_done(); @(negedge clk);
    chk(limit_fault == 1, "R6 fault", 32'(limit_fault), 1);
    chk(op_pulses == LIM, "R5 pulses", op_pulses, LIM);
    chk(mem[3] == 8'hA5, "R6 mem", mem[3], 8'hA5);

    // R7 fault ignores requests
    prog_req = 1; req_addr = 8; req_data = 8'h00; @(negedge clk); prog_req = 0;
    erase_req = 1; @(negedge clk); erase_req = 0;
    repeat (4) @(negedge clk);
    chk(op_pulses == LIM, "R7 no pulse", op_pulses, LIM);
    chk(limit_fault && busy, "R7 held", {limit_fault, busy}, 3);
    chk(mem[8] == 8'hFF, "R7 mem", mem[8], 8'hFF);
    t0 = status_tog;
    status_rd = 1; @(negedge clk); status_rd = 0;
    chk(status_tog == ~t0, "R8 fault read", 32'(status_tog), 32'(~t0));
    send_reset();
    chk(!limit_fault && !busy, "R7 release", {limit_fault, busy}, 0);

    // R9 erase
    start_erase(3, 2);
    wait_done(); @(negedge clk);
    chk(mem[3] == 8'hFF, "R9 mem", mem[3], 8'hFF);
    chk(last_erase == 1, "R9 flag", 32'(last_erase), 1);
    chk(op_pulses == 2, "R9 pulses", op_pulses, 2);

    // R10 requests and reset ignored while running
    start_prog(6, 8'h81, 3);
    prog_req = 1; erase_req = 1; reset_cmd = 1; req_addr = 9; req_data = 8'h00;
    @(negedge clk); @(negedge clk);
    prog_req = 0; erase_req = 0; reset_cmd = 0;
    wait_done(); @(negedge clk);
    chk(mem[6] == 8'h81, "R10 mem", mem[6], 8'h81);
    chk(mem[9] == 8'hFF, "R10 other", mem[9], 8'hFF);
    chk(op_pulses == 3, "R10 pulses", op_pulses, 3);

    // R5 boundary: one pulse too many needed
    start_prog(7, 8'h55, LIM + 1);
    wait_done(); @(negedge clk);
    chk(limit_fault == 1, "R5 late", 32'(limit_fault), 1);
    send_reset();
    // R11 budget restarts; success on the last pulse
    start_prog(7, 8'h55, LIM);
    wait_done(); @(negedge clk);
    chk(!limit_fault && !busy, "R11 done", {limit_fault, busy}, 0);
    chk(op_pulses == LIM, "R11 pulses", op_pulses, LIM);
    chk(mem[7] == 8'h55, "R11 mem", mem[7], 8'h55);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule